// File: doc/BRIEF.md
# System I/O Port Register Block

This block sits on a byte-wide I/O-port bus and answers a small fixed set of 16-bit port addresses that hold platform control state. Some ports can be read and written, some can only be read and some can only be written. A few writes do more than store data. One drives a soft-reset request line. One raises a sticky fault flag when a software request for little-endian operation arrives, because that mode is not supported. One selects the I/O address map mode, which a neighbouring address translator uses.

Read data is combinational from the current register state and the static configuration inputs. It is valid in the same cycle as the read strobe. A write takes effect at the next rising clock edge. A separate 4-byte memory-mapped window reports parity-error status. That window always reads as zero and rejects any access that is not 32 bits wide. The equipment and board-identity bytes come from configuration inputs that are tied off at integration.

Bit numbering inside each byte is MSB-first. Architectural bit n is the data bit at position 7 - n, so architectural bit 7 is data bit 0.

Top module: `sysio_regs`

## Requirements
- R1: While rst_n is low at a rising edge, the following edge leaves these reset values: soft_rst_o low, le_fault_o low, map_noncontig_o high, the control register at 0x81C zero. A read of port 0x850 returns 0x01 after reset.
- R2: A write to port 0x092 stores data bit 0 as the soft-reset bit. From the next cycle soft_rst_o equals that bit, and a read of 0x092 returns it in bit 0 with all other bits zero.
- R3: A write to port 0x092 with data bit 1 set (mask 0x02) sets le_fault_o from the next cycle. That bit is never stored, so it reads back as 0. le_fault_o then stays high through later writes until reset.
- R4: Port 0x81C keeps only the bits under mask 0xF0. Every other bit reads back as zero.
- R5: Port 0x850 keeps only data bit 0, and map_noncontig_o always shows the stored bit.
- R6: Port 0x80C returns cfg_equip and port 0x852 returns cfg_board_id, both live. A write to either port gives no hit and changes nothing.
- R7: Port 0x818 reads as 0x00 with io_hit high.
- R8: Ports 0x808, 0x810, 0x812 and 0x814 accept writes with io_hit high but change no state. A read of any of them returns 0xFF with io_hit low.
- R9: A read of an unmapped port returns 0xFF with io_hit low. A write to an unmapped port gives io_hit low and changes no state.
- R10: When mem_sel is high and mem_size is 2'b10 (32 bits), mem_err is low. Any other mem_size gives mem_err high. mem_rdata is always zero, and mem_err is low whenever mem_sel is low.
- R11: io_hit and io_rdata answer in the same cycle as the strobe. A written value is not visible on the outputs until after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, 0xFF when nothing readable is addressed |
| io_hit | output | 1 | Access decoded to a port that supports its direction |
| cfg_equip | input | 8 | Equipment configuration byte |
| cfg_board_id | input | 8 | Board identity byte |
| mem_sel | input | 1 | Parity window access |
| mem_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 reserved |
| mem_rdata | output | 32 | Parity window read data |
| mem_err | output | 1 | Error response for a window access that is not 32 bits |
| soft_rst_o | output | 1 | Soft-reset request |
| le_fault_o | output | 1 | Sticky unsupported-endianness fault |
| map_noncontig_o | output | 1 | Non-contiguous I/O map mode |

## Verification
The assertions check on every cycle the things that hold at any time. These are the reset values, that the fault flag never drops outside reset, that the soft-reset line follows the last write to its port, that the map-mode line only moves on a write to its own port, that a miss reads 0xFF, and the error response of the parity window. Other behaviour depends on particular data patterns, so only the bench scenarios can show it. This covers the write mask of the control register, the live path from the configuration inputs, the fact that writes to write-only and unmapped ports leave every stored register unchanged, and the one-cycle delay before a write becomes visible.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    localparam int NPORT = 10;

    // Port indices into the decode table
    localparam int IX_SRST   = 0;
    localparam int IX_LIGHT  = 1;
    localparam int IX_EQUIP  = 2;
    localparam int IX_PW1    = 3;
    localparam int IX_PW2    = 4;
    localparam int IX_L2INV  = 5;
    localparam int IX_KEY    = 6;
    localparam int IX_CTL    = 7;
    localparam int IX_MAP    = 8;
    localparam int IX_BOARD  = 9;

    localparam logic [15:0] PORT_ADDR [NPORT] = '{
        16'h0092, 16'h0808, 16'h080C, 16'h0810, 16'h0812,
        16'h0814, 16'h0818, 16'h081C, 16'h0850, 16'h0852
    };

    // Direction capability per index (bit i = index i)
    localparam logic [NPORT-1:0] RD_CAP = 10'b11_1100_0101;
    localparam logic [NPORT-1:0] WR_CAP = 10'b01_1011_1011;

    // MSB-first numbering: architectural bit n is data bit 7-n
    localparam logic [7:0] SRST_MASK = 8'h01; // arch bit 7
    localparam logic [7:0] LE_MASK   = 8'h02; // arch bit 6
    localparam logic [7:0] CTL_MASK  = 8'hF0; // arch bits 0..3
    localparam logic [7:0] MAP_MASK  = 8'h01; // arch bit 7

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic       srst;
        logic [7:0] ctl;
        logic       map;
        logic       fault;
    } sysio_regs_t;

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
    import sysio_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NPORT-1:0]  sel,
    output logic              rd_ok,
    output logic              wr_ok
);

    for (genvar i = 0; i < NPORT; i++) begin : g_cmp
        assign sel[i] = (addr == ADDR_W'(PORT_ADDR[i]));
    end

    assign rd_ok = |(sel & RD_CAP);
    assign wr_ok = |(sel & WR_CAP);

endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win
    import sysio_pkg::*;
#(
    parameter int WIN_W = 32
) (
    input  logic             sel,
    input  logic [1:0]       size,
    output logic [WIN_W-1:0] rdata,
    output logic             err
);

    always_comb begin
        rdata = '0;
        err   = sel && (size != SZ_WORD);
    end

endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
    import sysio_pkg::*;
#(
    parameter int   ADDR_W  = 16,
    parameter int   WIN_W   = 32,
    parameter logic RST_MAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    output logic              io_hit,
    input  logic [7:0]        cfg_equip,
    input  logic [7:0]        cfg_board_id,
    input  logic              mem_sel,
    input  logic [1:0]        mem_size,
    output logic [WIN_W-1:0]  mem_rdata,
    output logic              mem_err,
    output logic              soft_rst_o,
    output logic              le_fault_o,
    output logic              map_noncontig_o
);

    localparam sysio_regs_t RST_VAL = '{srst: 1'b0, ctl: 8'h00, map: RST_MAP, fault: 1'b0};

    logic [NPORT-1:0] sel;
    logic             rd_ok;
    logic             wr_ok;
    sysio_regs_t      regs_d, regs_q;

    sysio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (io_addr),
        .sel   (sel),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    sysio_parity_win #(.WIN_W(WIN_W)) u_par (
        .sel   (mem_sel),
        .size  (mem_size),
        .rdata (mem_rdata),
        .err   (mem_err)
    );

    always_comb begin
        regs_d   = regs_q;
        io_rdata = 8'hFF;
        io_hit   = (io_rd && rd_ok) || (io_wr && wr_ok);

        if (io_wr) begin
            if (sel[IX_SRST]) begin
                regs_d.srst = |(io_wdata & SRST_MASK);
                if (|(io_wdata & LE_MASK)) begin
                    regs_d.fault = 1'b1;
                end
            end
            if (sel[IX_CTL]) begin
                regs_d.ctl = io_wdata & CTL_MASK;
            end
            if (sel[IX_MAP]) begin
                regs_d.map = |(io_wdata & MAP_MASK);
            end
        end

        if (io_rd && rd_ok) begin
            unique case (1'b1)
                sel[IX_SRST]:  io_rdata = regs_q.srst ? SRST_MASK : 8'h00;
                sel[IX_EQUIP]: io_rdata = cfg_equip;
                sel[IX_KEY]:   io_rdata = 8'h00;
                sel[IX_CTL]:   io_rdata = regs_q.ctl;
                sel[IX_MAP]:   io_rdata = regs_q.map ? MAP_MASK : 8'h00;
                sel[IX_BOARD]: io_rdata = cfg_board_id;
                default:       io_rdata = 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= RST_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign soft_rst_o      = regs_q.srst;
    assign le_fault_o      = regs_q.fault;
    assign map_noncontig_o = regs_q.map;

endmodule

// File: rtl/sysio_regs_chk.sv
module sysio_regs_chk
    import sysio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [1:0]        wdata_lo,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_rdata,
    input logic              io_hit,
    input logic              mem_sel,
    input logic [1:0]        mem_size,
    input logic [WIN_W-1:0]  mem_rdata,
    input logic              mem_err,
    input logic              soft_rst_o,
    input logic              le_fault_o,
    input logic              map_noncontig_o
);

    logic srst_wr;
    logic map_wr;
    assign srst_wr = io_wr && (io_addr == ADDR_W'(PORT_ADDR[IX_SRST]));
    assign map_wr  = io_wr && (io_addr == ADDR_W'(PORT_ADDR[IX_MAP]));

    // R1
    reset_vals_chk: assert property (@(posedge clk)
        !rst_n |=> (!soft_rst_o && !le_fault_o && map_noncontig_o));

    // R2
    srst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (soft_rst_o == $past(wdata_lo[0])));

    // R3
    fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_wr && wdata_lo[1]) |=> le_fault_o);

    // R3
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_fault_o |=> le_fault_o);

    // R5
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !map_wr |=> $stable(map_noncontig_o));

    // R9
    miss_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && !io_hit) |-> (io_rdata == 8'hFF));

    // R10
    win_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (mem_err == (mem_size != SZ_WORD)));

    // R10
    win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rdata == '0) && (mem_sel || !mem_err));

endmodule

bind sysio_regs sysio_regs_chk #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .io_addr         (io_addr),
    .wdata_lo        (io_wdata[1:0]),
    .io_wr           (io_wr),
    .io_rd           (io_rd),
    .io_rdata        (io_rdata),
    .io_hit          (io_hit),
    .mem_sel         (mem_sel),
    .mem_size        (mem_size),
    .mem_rdata       (mem_rdata),
    .mem_err         (mem_err),
    .soft_rst_o      (soft_rst_o),
    .le_fault_o      (le_fault_o),
    .map_noncontig_o (map_noncontig_o)
);

// File: tb/sysio_regs_tb.sv
`timescale 1ns/1ps
module sysio_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic [7:0]  cfg_equip = 8'hA5;
    logic [7:0]  cfg_board_id = 8'h3C;
    logic        mem_sel = 1'b0;
    logic [1:0]  mem_size = 2'b00;
    logic [31:0] mem_rdata;
    logic        mem_err;
    logic        soft_rst_o, le_fault_o, map_noncontig_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sysio_regs u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_hit(io_hit),
        .cfg_equip(cfg_equip), .cfg_board_id(cfg_board_id),
        .mem_sel(mem_sel), .mem_size(mem_size), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .soft_rst_o(soft_rst_o), .le_fault_o(le_fault_o),
        .map_noncontig_o(map_noncontig_o)
    );

    typedef struct packed {
        logic       wr;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic        hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 29;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 16'h0850, 8'h00, 8'h01, 1'b1, 4'd1},  // R1
        '{1'b0, 16'h0092, 8'h00, 8'h00, 1'b1, 4'd1},
        '{1'b0, 16'h081C, 8'h00, 8'h00, 1'b1, 4'd1},
        '{1'b1, 16'h081C, 8'hFF, 8'h00, 1'b1, 4'd4},  // R4
        '{1'b0, 16'h081C, 8'h00, 8'hF0, 1'b1, 4'd4},
        '{1'b1, 16'h081C, 8'h5A, 8'h00, 1'b1, 4'd4},
        '{1'b0, 16'h081C, 8'h00, 8'h50, 1'b1, 4'd4},
        '{1'b1, 16'h0850, 8'hFE, 8'h00, 1'b1, 4'd5},  // R5
        '{1'b0, 16'h0850, 8'h00, 8'h00, 1'b1, 4'd5},
        '{1'b1, 16'h0850, 8'h01, 8'h00, 1'b1, 4'd5},
        '{1'b0, 16'h0850, 8'h00, 8'h01, 1'b1, 4'd5},
        '{1'b0, 16'h080C, 8'h00, 8'hA5, 1'b1, 4'd6},  // R6
        '{1'b1, 16'h080C, 8'h00, 8'h00, 1'b0, 4'd6},
        '{1'b0, 16'h080C, 8'h00, 8'hA5, 1'b1, 4'd6},
        '{1'b0, 16'h0852, 8'h00, 8'h3C, 1'b1, 4'd6},
        '{1'b0, 16'h0818, 8'h00, 8'h00, 1'b1, 4'd7},  // R7
        '{1'b1, 16'h0808, 8'hFF, 8'h00, 1'b1, 4'd8},  // R8
        '{1'b0, 16'h0808, 8'h00, 8'hFF, 1'b0, 4'd8},
        '{1'b1, 16'h0810, 8'h55, 8'h00, 1'b1, 4'd8},
        '{1'b1, 16'h0812, 8'hAA, 8'h00, 1'b1, 4'd8},
        '{1'b1, 16'h0814, 8'hFF, 8'h00, 1'b1, 4'd8},
        '{1'b0, 16'h0814, 8'h00, 8'hFF, 1'b0, 4'd8},
        '{1'b0, 16'h0093, 8'h00, 8'hFF, 1'b0, 4'd9},  // R9
        '{1'b1, 16'h0093, 8'hFF, 8'h00, 1'b0, 4'd9},
        '{1'b0, 16'h081C, 8'h00, 8'h50, 1'b1, 4'd9},
        '{1'b1, 16'h0092, 8'h01, 8'h00, 1'b1, 4'd2},  // R2
        '{1'b0, 16'h0092, 8'h00, 8'h01, 1'b1, 4'd2},
        '{1'b1, 16'h0092, 8'h00, 8'h00, 1'b1, 4'd2},
        '{1'b0, 16'h0092, 8'h00, 8'h00, 1'b1, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Drive at a falling edge, sample combinational outputs 1 ns later,
    // release the strobe just after the next rising edge.
    task automatic io_acc(input logic wr, input logic [15:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output logic h);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
        #1;
        rd = io_rdata; h = io_hit;
        @(posedge clk);
        #0.5;
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        logic h;
        do_reset();
        @(negedge clk);
        // R1 reset outputs
        check("R1 soft_rst_o", soft_rst_o, 0);
        check("R1 le_fault_o", le_fault_o, 0);
        check("R1 map_noncontig_o", map_noncontig_o, 1);

        for (int i = 0; i < NVEC; i++) begin
            io_acc(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, h);
            total++;
            if (h !== VEC[i].hit || (!VEC[i].wr && rd !== VEC[i].exp)) begin
                bad++;
                $display("FAIL R%0d vec %0d addr=%h actual rd=%h hit=%b expected rd=%h hit=%b",
                         VEC[i].req, i, VEC[i].addr, rd, h, VEC[i].exp, VEC[i].hit);
            end
        end

        // R2 output follows write
        io_acc(1'b1, 16'h0092, 8'h01, rd, h);
        @(negedge clk);
        check("R2 soft_rst_o set", soft_rst_o, 1);
        check("R3 no fault on plain write", le_fault_o, 0);

        // R3 endianness request
        io_acc(1'b1, 16'h0092, 8'h02, rd, h);
        @(negedge clk);
        check("R3 fault raised", le_fault_o, 1);
        check("R2 soft_rst_o cleared", soft_rst_o, 0);
        io_acc(1'b0, 16'h0092, 8'h00, rd, h);
        check("R3 bit not stored", rd, 8'h00);
        io_acc(1'b1, 16'h0092, 8'h03, rd, h);
        io_acc(1'b0, 16'h0092, 8'h00, rd, h);
        check("R3 read 0x03 write", rd, 8'h01);
        io_acc(1'b1, 16'h0092, 8'h00, rd, h);
        @(negedge clk);
        check("R3 fault sticky", le_fault_o, 1);

        // R11 write not visible before edge; R5 output
        @(negedge clk);
        io_addr = 16'h0850; io_wdata = 8'h00; io_wr = 1'b1;
        #1;
        check("R11 same-cycle hit", io_hit, 1);
        check("R11 map before edge", map_noncontig_o, 1);
        @(posedge clk); #0.5 io_wr = 1'b0;
        @(negedge clk);
        check("R5 map output low", map_noncontig_o, 0);

        // R8 write-only writes leave state alone
        io_acc(1'b1, 16'h0808, 8'hFF, rd, h);
        io_acc(1'b1, 16'h0814, 8'hFF, rd, h);
        @(negedge clk);
        check("R8 map unchanged", map_noncontig_o, 0);
        check("R8 soft_rst unchanged", soft_rst_o, 0);

        // R6 live configuration
        cfg_equip = 8'h5A; cfg_board_id = 8'hC3;
        io_acc(1'b0, 16'h080C, 8'h00, rd, h);
        check("R6 equip live", rd, 8'h5A);
        io_acc(1'b0, 16'h0852, 8'h00, rd, h);
        check("R6 board live", rd, 8'hC3);

        // R10 parity window
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            mem_sel = 1'b1; mem_size = 2'(s);
            #1;
            check("R10 mem_err", mem_err, (s != 2) ? 1 : 0);
            check("R10 mem_rdata", mem_rdata, 0);
        end
        @(negedge clk); mem_sel = 1'b0; mem_size = 2'b11; #1;
        check("R10 idle no err", mem_err, 0);

        // R1 reset clears fault, restores defaults
        do_reset();
        @(negedge clk);
        check("R1 fault cleared", le_fault_o, 0);
        check("R1 map restored", map_noncontig_o, 1);
        io_acc(1'b0, 16'h081C, 8'h00, rd, h);
        check("R1 ctl cleared", rd, 8'h00);

        done = 1;
        finish_run();
    end

endmodule